// File: doc/BRIEF.md
# Oversampled I2C Register Target with Auto-Increment

This block lets an external two-wire master read and write bytes in a 256-location configuration space. It does not use SCL as a clock. SCL and SDA are sampled on a fast system clock, synchronized, and filtered for glitches. After that, the block finds START, repeated START and STOP from the filtered edges. A 7-bit device address is matched and the direction bit is captured. The first byte of a write frame loads an 8-bit address pointer. Each following data byte is written at the pointer, and the pointer then advances.

The pointer is kept between transactions. A read frame that starts without a register address returns the byte at the pointer, which is one past the last location written or read. A write frame that carries only a register address, followed by a repeated START and a read header, therefore performs a random read. Sequential reads continue for as long as the master acknowledges. The pointer wraps from FFh to 00h.

Only two address windows hold real registers. Writes outside them are acknowledged but never reach the bank, and reads outside them return zero. The bank is reached through a plain parallel port with a combinational read path.

Top module: `cfg_i2c_target`

## Requirements
- R1: Only a header whose upper seven bits equal DEV_ADDR (default 47h) is acknowledged. Any other header gets no acknowledge, and the rest of that frame produces no write strobe and leaves the pointer unchanged.
- R2: In a write frame, each data byte after the register-address byte gives a one-cycle reg_we pulse. reg_addr equals the pointer and reg_wdata equals the byte, and the pointer then advances by one.
- R3: The target pulls SDA low during the ninth SCL clock of every byte it receives: the matching header, the register address and each data byte.
- R4: A read frame started directly after START returns the byte at the current pointer. The pointer persists across frames and equals one more than the last location accessed, and this value is visible on reg_addr while the bus is idle.
- R5: A write frame holding only a register address, followed by a repeated START and a read header, returns the byte at that register address, with no write strobe.
- R6: During a read, a master acknowledge (SDA low on the ninth clock) makes the target send the byte at the next address. A master NACK ends the read, and SDA is released.
- R7: The pointer wraps from FFh to 00h on increment, for both writes and reads.
- R8: Real registers are 0Ah to 17h and 40h to 57h inclusive. Writes elsewhere are acknowledged but raise no reg_we, and reads elsewhere return 00h.
- R9: A STOP in the middle of a byte discards that byte and returns the target to idle. A START in the middle of a byte restarts header reception.
- R10: After reset sda_oe is low, reg_we is low and the pointer (reg_addr) is 00h.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | 8 | Register bank address: the write address during a strobe, otherwise the pointer |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe, one cycle |
| reg_rdata | input | 8 | Register bank read data for reg_addr, combinational |

## Verification
The bench builds the target with its default parameters: device address 47h, two synchronizer stages, a filter length of three clocks, and the two default register windows. A quarter SCL bit lasts twelve system clocks, so a two-clock pulse on SCL falls below the filter threshold while real edges pass with margin. The bench can then check that a glitched write still lands correctly. The default windows place 17h/18h and 57h at window edges and FEh/FFh/00h outside them, so pointer wrap and discarded writes can be observed on reg_addr and reg_we.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_REG,
        S_REG_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e st;
        logic [3:0] bits;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic [7:0] waddr;
        logic       we;
        logic       oe;
        logic       rw;
        logic       mack;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
        logic                   prev;
    } flt_t;

    flt_t q, d;
    logic settled;

    assign settled = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], line_i};
        d.prev = q.out;
        if (settled != q.out) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.out = settled;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
            q.out  <= 1'b1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.out;
    assign rise_o = q.out & ~q.prev;
    assign fall_o = ~q.out & q.prev;

    AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> q.out == $past(settled)); // R11

endmodule

// File: rtl/i2c_reg_window.sv
module i2c_reg_window #(
    parameter logic [7:0] LO_FIRST = 8'h0A,
    parameter logic [7:0] LO_LAST  = 8'h17,
    parameter logic [7:0] HI_FIRST = 8'h40,
    parameter logic [7:0] HI_LAST  = 8'h57
) (
    input  logic [7:0] addr_i,
    input  logic       we_i,
    input  logic [7:0] rdata_i,
    output logic       we_o,
    output logic [7:0] rdata_o
);
    logic hit;

    always_comb begin
        hit     = ((addr_i >= LO_FIRST) && (addr_i <= LO_LAST)) ||
                  ((addr_i >= HI_FIRST) && (addr_i <= HI_LAST));
        we_o    = we_i & hit;
        rdata_o = hit ? rdata_i : 8'h00;
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h47
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data_i,
    output logic [7:0] bank_addr_o,
    output logic [7:0] bank_wdata_o,
    output logic       bank_we_o,
    output logic       sda_oe_o
);
    tgt_regs_t q, d;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.st   = S_IDLE;
            d.oe   = 1'b0;
            d.bits = '0;
        end else if (start_det) begin
            d.st   = S_DEV;
            d.oe   = 1'b0;
            d.bits = '0;
        end else begin
            case (q.st)
                S_DEV, S_REG, S_WR: begin
                    if (scl_rise && (q.bits < 4'd8)) begin
                        d.sh   = {q.sh[6:0], sda_f};
                        d.bits = q.bits + 4'd1;
                    end
                    if (scl_fall && (q.bits == 4'd8)) begin
                        d.bits = '0;
                        case (q.st)
                            S_DEV: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.rw = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = S_DEV_ACK;
                                end else begin
                                    d.st = S_IDLE;
                                end
                            end
                            S_REG: begin
                                d.ptr = q.sh;
                                d.oe  = 1'b1;
                                d.st  = S_REG_ACK;
                            end
                            default: begin
                                d.we    = 1'b1;
                                d.waddr = q.ptr;
                                d.ptr   = q.ptr + 8'd1;
                                d.oe    = 1'b1;
                                d.st    = S_WR_ACK;
                            end
                        endcase
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.st = S_RD;
                            d.sh = rd_data_i;
                            d.oe = ~rd_data_i[7];
                        end else begin
                            d.st = S_REG;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_REG_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        d.st = S_WR;
                        d.oe = 1'b0;
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            d.oe   = 1'b0;
                            d.bits = '0;
                            d.ptr  = q.ptr + 8'd1;
                            d.st   = S_RD_ACK;
                        end else begin
                            d.bits = q.bits + 4'd1;
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_f;
                    end
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st   = S_RD;
                            d.sh   = rd_data_i;
                            d.oe   = ~rd_data_i[7];
                            d.bits = '0;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, bits: '0, sh: '0, ptr: '0, waddr: '0,
                   we: 1'b0, oe: 1'b0, rw: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bank_addr_o  = q.we ? q.waddr : q.ptr;
    assign bank_wdata_o = q.sh;
    assign bank_we_o    = q.we;
    assign sda_oe_o     = q.oe;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_f); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> q.ptr == q.waddr + 8'd1); // R7
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == S_IDLE) && !q.oe); // R9
    AST_START_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (q.st == S_DEV) && (q.bits == 4'd0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> !q.oe); // R1

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h47,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [7:0] LO_FIRST    = 8'h0A,
    parameter logic [7:0] LO_LAST     = 8'h17,
    parameter logic [7:0] HI_FIRST    = 8'h40,
    parameter logic [7:0] HI_LAST     = 8'h57
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam int NLINES = 2;   // index 0 = SCL, 1 = SDA

    logic [NLINES-1:0] raw, filt, rise, fall;
    logic              start_det, stop_det;
    logic              fsm_we;
    logic [7:0]        win_rdata;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .line_o (filt[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    assign start_det = filt[0] & fall[1];
    assign stop_det  = filt[0] & rise[1];

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_f        (filt[0]),
        .sda_f        (filt[1]),
        .scl_rise     (rise[0]),
        .scl_fall     (fall[0]),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .rd_data_i    (win_rdata),
        .bank_addr_o  (reg_addr),
        .bank_wdata_o (reg_wdata),
        .bank_we_o    (fsm_we),
        .sda_oe_o     (sda_oe)
    );

    i2c_reg_window #(
        .LO_FIRST (LO_FIRST),
        .LO_LAST  (LO_LAST),
        .HI_FIRST (HI_FIRST),
        .HI_LAST  (HI_LAST)
    ) u_win (
        .addr_i  (reg_addr),
        .we_i    (fsm_we),
        .rdata_i (reg_rdata),
        .we_o    (reg_we),
        .rdata_o (win_rdata)
    );

endmodule

// File: tb/tb_cfg_i2c_target.sv
module tb_cfg_i2c_target;
    localparam int Q = 12;
    localparam logic [6:0] DA = 7'h47;
    localparam logic [1:0] K_WR = 2'd0, K_CR = 2'd1, K_RR = 2'd2;
    localparam int NV = 12;
    // {kind, register, data}
    localparam logic [17:0] VEC [NV] = '{
        {K_WR, 8'h0A, 8'h3C}, {K_RR, 8'h0A, 8'h00}, {K_WR, 8'h17, 8'hC3},
        {K_CR, 8'h00, 8'h00}, {K_WR, 8'h40, 8'h81}, {K_WR, 8'h41, 8'h7E},
        {K_RR, 8'h40, 8'h00}, {K_CR, 8'h00, 8'h00}, {K_RR, 8'h57, 8'h00},
        {K_WR, 8'h30, 8'h99}, {K_RR, 8'h30, 8'h00}, {K_CR, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, m_low = 1'b0;
    logic sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_bus;
    logic [7:0] bank [256];
    int   wcnt;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] mbank [256];
    logic [7:0] mptr;

    always #2 clk = ~clk;

    assign sda_bus   = ~(sda_oe | m_low);
    assign reg_rdata = bank[reg_addr];

    cfg_i2c_target #(.DEV_ADDR(DA)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'hA5;
            wcnt <= 0;
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            wcnt <= wcnt + 1;
        end
    end

    function automatic logic real_reg(input logic [7:0] a);
        return (a >= 8'h0A && a <= 8'h17) || (a >= 8'h40 && a <= 8'h57);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic drive, input logic glitch, output logic seen);
        m_low = ~drive;
        if (glitch) begin
            repeat (4) @(negedge clk);
            scl = 1'b1;
            repeat (2) @(negedge clk);
            scl = 1'b0;
            repeat (Q - 6) @(negedge clk);
        end else begin
            wq();
        end
        scl = 1'b1;
        wq();
        seen = sda_bus;
        wq();
        scl = 1'b0;
        wq();
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq();
        scl = 1'b1;   wq();
        m_low = 1'b1; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq();
        scl = 1'b1;   wq();
        m_low = 1'b0; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, s);
        clk_bit(1'b1, 1'b0, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, s);
            b[i] = s;
        end
        clk_bit(~ack, 1'b0, s);
    endtask

    function automatic logic [7:0] expect_at(input logic [7:0] a);
        return real_reg(a) ? mbank[a] : 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] rb;
        int w0;
        for (int i = 0; i < 256; i++) mbank[i] = 8'(i) ^ 8'hA5;
        mptr = 8'h00;
        repeat (10) @(negedge clk);
        check8("R10 sda_oe in reset", {7'b0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check8("R10 reg_we after reset", {7'b0, reg_we}, 8'h00);
        check8("R10 pointer after reset", reg_addr, 8'h00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] kd;
            logic [7:0] ra, dt;
            kd = VEC[v][17:16]; ra = VEC[v][15:8]; dt = VEC[v][7:0];
            w0 = wcnt;
            i2c_start();
            if (kd == K_CR) begin
                send_byte({DA, 1'b1}, 1'b0, ak);
                check8("R1 read header ack", {7'b0, ak}, 8'h01);
                recv_byte(1'b0, rb);
                i2c_stop();
                check8("R4 current-address read", rb, expect_at(mptr));
                mptr = mptr + 8'd1;
            end else begin
                send_byte({DA, 1'b0}, 1'b0, ak);
                check8("R3 header ack", {7'b0, ak}, 8'h01);
                send_byte(ra, 1'b0, ak);
                check8("R3 register ack", {7'b0, ak}, 8'h01);
                if (kd == K_WR) begin
                    send_byte(dt, 1'b0, ak);
                    check8("R3 data ack", {7'b0, ak}, 8'h01);
                    i2c_stop();
                    check8("R8 strobe only in window", 8'(wcnt - w0), {7'b0, real_reg(ra)});
                    if (real_reg(ra)) mbank[ra] = dt;
                end else begin
                    i2c_start();
                    send_byte({DA, 1'b1}, 1'b0, ak);
                    check8("R5 repeated-start header ack", {7'b0, ak}, 8'h01);
                    recv_byte(1'b0, rb);
                    i2c_stop();
                    check8("R5 random read data", rb, expect_at(ra));
                    check8("R5 no strobe on random read", 8'(wcnt - w0), 8'h00);
                end
                mptr = ra + 8'd1;
            end
        end
        check8("R4 pointer persists on reg_addr", reg_addr, mptr);

        // R1: foreign address ignored
        w0 = wcnt;
        i2c_start();
        send_byte({7'h46, 1'b0}, 1'b0, ak);
        check8("R1 foreign header nack", {7'b0, ak}, 8'h00);
        send_byte(8'h0B, 1'b0, ak);
        send_byte(8'h55, 1'b0, ak);
        i2c_stop();
        check8("R1 foreign frame no strobe", 8'(wcnt - w0), 8'h00);
        check8("R1 foreign frame pointer kept", reg_addr, mptr);

        // R2 + R6: burst write then sequential read
        w0 = wcnt;
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'h0E, 1'b0, ak);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h11 * 8'(i + 1), 1'b0, ak);
            check8("R3 burst data ack", {7'b0, ak}, 8'h01);
            mbank[8'h0E + 8'(i)] = 8'h11 * 8'(i + 1);
        end
        i2c_stop();
        check8("R2 burst strobe count", 8'(wcnt - w0), 8'h03);
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'h0E, 1'b0, ak);
        i2c_start();
        send_byte({DA, 1'b1}, 1'b0, ak);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i < 2, rb);
            check8("R6 sequential read byte", rb, 8'h11 * 8'(i + 1));
        end
        i2c_stop();
        check8("R6 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
        mptr = 8'h11;

        // R7: write wrap FE -> FF -> 00
        w0 = wcnt;
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'hFE, 1'b0, ak);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hE0 + 8'(i), 1'b0, ak);
            check8("R8 ack outside window", {7'b0, ak}, 8'h01);
        end
        i2c_stop();
        check8("R8 no strobe outside window", 8'(wcnt - w0), 8'h00);
        check8("R7 write pointer wrapped", reg_addr, 8'h01);

        // R7: read wrap FF -> 00
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'hFF, 1'b0, ak);
        i2c_start();
        send_byte({DA, 1'b1}, 1'b0, ak);
        recv_byte(1'b1, rb);
        check8("R8 read outside window is zero", rb, 8'h00);
        recv_byte(1'b0, rb);
        i2c_stop();
        check8("R7 read pointer wrapped", reg_addr, 8'h01);

        // R9: STOP mid-byte
        w0 = wcnt;
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'h10, 1'b0, ak);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, ak);
        i2c_stop();
        check8("R9 stop mid-byte no strobe", 8'(wcnt - w0), 8'h00);
        i2c_start();
        send_byte({DA, 1'b1}, 1'b0, ak);
        recv_byte(1'b0, rb);
        i2c_stop();
        check8("R9 pointer set before aborted byte", rb, expect_at(8'h10));

        // R9: START mid-byte
        i2c_start();
        for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, ak);
        i2c_start();
        send_byte({DA, 1'b1}, 1'b0, ak);
        check8("R9 header after mid-byte start", {7'b0, ak}, 8'h01);
        recv_byte(1'b0, rb);
        i2c_stop();
        check8("R9 read after mid-byte start", rb, expect_at(8'h11));

        // R11: short SCL pulses ignored
        w0 = wcnt;
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'h15, 1'b0, ak);
        send_byte(8'hA6, 1'b1, ak);
        check8("R11 glitched byte acked", {7'b0, ak}, 8'h01);
        i2c_stop();
        check8("R11 one strobe for glitched byte", 8'(wcnt - w0), 8'h01);
        mbank[8'h15] = 8'hA6;
        i2c_start();
        send_byte({DA, 1'b0}, 1'b0, ak);
        send_byte(8'h15, 1'b0, ak);
        i2c_start();
        send_byte({DA, 1'b1}, 1'b0, ak);
        recv_byte(1'b0, rb);
        i2c_stop();
        check8("R11 glitched byte stored intact", rb, 8'hA6);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule